// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a very small accumulator processor. It runs a fixed fetch, decode and execute loop as a sequence of separate register transfers. The transfers pass through a program counter, an address latch, a data latch, an instruction register and an 8-bit accumulator. Only the address latch drives the 16-word internal memory. Only the data latch receives what the memory returns. The memory holds both the program and its data.

A host fills the memory through a byte-wide load port while the processor is idle after reset, or once it has halted. A single-cycle pulse on `start` then begins execution at address 0. Results appear on an 8-bit output bus, marked by a one-cycle valid strobe. A halt instruction parks the processor and sets a flag that stays set until reset.

Each instruction word is a 4-bit operation code in the upper nibble and a 4-bit direct memory address in the lower nibble. Six operations are defined: load, add, store, output, unconditional jump and halt. Every other code does nothing beyond its fetch.

Top module: `acc_cpu_top`

## Requirements
- R1: After reset, the processor idles with the program counter at 0. `halted`, `out_valid` and `out_data` are all low, and it stays that way until `start` is seen.
- R2: Every instruction begins with four fetch cycles: the address latch takes the PC, memory is read into the data latch, the data latch moves into the instruction register, and the PC steps by one. A decode cycle follows.
- R3: Bits [7:4] of an instruction word are the operation code and bits [3:0] are the operand address.
- R4: Code 0001 (load) copies the word at the operand address into the accumulator. The instruction takes 8 cycles.
- R5: Code 0010 (add) adds the word at the operand address to the accumulator, modulo 256. The instruction takes 8 cycles.
- R6: Code 0011 (store) writes the accumulator to the operand address and leaves the accumulator unchanged. The instruction takes 7 cycles.
- R7: Code 0101 (output) takes 6 cycles. `out_valid` is high for exactly one cycle, in the cycle after its last state. `out_data` carries the accumulator value and holds it until the next output.
- R8: Code 0110 (jump) loads the PC with the operand, so that the next fetch reads from that address. The instruction takes 6 cycles.
- R9: Code 0000 (halt) raises `halted` 5 cycles after its fetch begins. The flag stays high until reset, no further fetch, strobe or `start` has any effect, and there is no output strobe afterwards.
- R10: Codes 0100 and 0111 through 1111 act as no-ops. They take 5 cycles and change neither the accumulator nor the PC beyond its step.
- R11: Load-port writes take effect only while the processor is idle or halted. A write attempted during execution is ignored, and memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution from address 0 |
| load_we | input | 1 | Load-port write enable |
| load_addr | input | 4 | Load-port word address |
| load_data | input | 8 | Load-port write data |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 8 | Last value output by the program |
| halted | output | 1 | Halt flag, sticky until reset |

## Verification
Cycles are counted from the clock edge at which `start` is sampled. The first fetch then occupies cycle 1, and each instruction adds its fixed length: 8 for load and add, 7 for store, 6 for output and jump, 5 for the others. An output strobe is due 6 cycles after its instruction's first fetch cycle, and `halted` is due 5 cycles after the halt's first fetch cycle. A reference interpreter in the bench walks each program image and queues every expected output value together with its due cycle. The monitor samples on the falling edge and requires each strobe to arrive on exactly its due cycle, with the queued value. Strobes outside a run, late halts and leftover queue entries are all reported.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 4'h0,
    OP_LOAD  = 4'h1,
    OP_ADD   = 4'h2,
    OP_STORE = 4'h3,
    OP_OUT   = 4'h5,
    OP_JUMP  = 4'h6
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_F_MAR,
    S_F_RD,
    S_F_CIR,
    S_F_INC,
    S_DEC,
    S_X_MAR,
    S_X_RD,
    S_X_ACC,
    S_X_WR,
    S_X_OUT,
    S_X_JMP,
    S_HALT
  } state_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_opd;
    logic mdr_ld;
    logic cir_ld;
    logic pc_inc;
    logic pc_ld;
    logic acc_ld;
    logic acc_add;
    logic mem_wr;
    logic out_ld;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DW-1:0] word_q;
    logic          word_en;

    assign word_en = we && (waddr == AW'(i));

    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q <= wdata;
      end
    end

    assign words[i] = word_q;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  output ctl_t            ctl,
  output logic            halted,
  output logic            mem_open
);

  state_e state_q;
  state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = S_F_MAR;
      S_F_MAR: state_d = S_F_RD;
      S_F_RD:  state_d = S_F_CIR;
      S_F_CIR: state_d = S_F_INC;
      S_F_INC: state_d = S_DEC;
      S_DEC: begin
        case (opcode)
          OP_LOAD, OP_ADD, OP_STORE: state_d = S_X_MAR;
          OP_OUT:                    state_d = S_X_OUT;
          OP_JUMP:                   state_d = S_X_JMP;
          OP_HALT:                   state_d = S_HALT;
          default:                   state_d = S_F_MAR;
        endcase
      end
      S_X_MAR: state_d = (opcode == OP_STORE) ? S_X_WR : S_X_RD;
      S_X_RD:  state_d = S_X_ACC;
      S_X_ACC: state_d = S_F_MAR;
      S_X_WR:  state_d = S_F_MAR;
      S_X_OUT: state_d = S_F_MAR;
      S_X_JMP: state_d = S_F_MAR;
      S_HALT:  state_d = S_HALT;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    ctl = '0;
    case (state_q)
      S_F_MAR: ctl.mar_pc  = 1'b1;
      S_F_RD:  ctl.mdr_ld  = 1'b1;
      S_F_CIR: ctl.cir_ld  = 1'b1;
      S_F_INC: ctl.pc_inc  = 1'b1;
      S_X_MAR: ctl.mar_opd = 1'b1;
      S_X_RD:  ctl.mdr_ld  = 1'b1;
      S_X_ACC: begin
        ctl.acc_ld  = 1'b1;
        ctl.acc_add = (opcode == OP_ADD);
      end
      S_X_WR:  ctl.mem_wr  = 1'b1;
      S_X_OUT: ctl.out_ld  = 1'b1;
      S_X_JMP: ctl.pc_ld   = 1'b1;
      default: ctl = '0;
    endcase
  end

  assign halted   = (state_q == S_HALT);
  assign mem_open = (state_q == S_IDLE) || (state_q == S_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9

  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !start) |=> !ctl.mar_pc && !ctl.mdr_ld); // R1

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  output logic [OP_W-1:0] opcode,
  output logic            out_valid,
  output logic [DW-1:0]   out_data
);

  logic [AW-1:0] pc_q,  pc_d;
  logic [AW-1:0] mar_q, mar_d;
  logic [DW-1:0] mdr_q, mdr_d;
  logic [DW-1:0] cir_q, cir_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] out_q, out_d;
  logic          vld_q;
  logic [AW-1:0] operand;

  assign operand = cir_q[AW-1:0];
  assign opcode  = cir_q[DW-1 -: OP_W];

  always_comb begin
    pc_d = pc_q;
    if (ctl.pc_ld) begin
      pc_d = operand;
    end else if (ctl.pc_inc) begin
      pc_d = pc_q + AW'(1);
    end

    mar_d = mar_q;
    if (ctl.mar_pc) begin
      mar_d = pc_q;
    end else if (ctl.mar_opd) begin
      mar_d = operand;
    end

    mdr_d = ctl.mdr_ld ? mem_rdata : mdr_q;
    cir_d = ctl.cir_ld ? mdr_q : cir_q;

    acc_d = acc_q;
    if (ctl.acc_ld) begin
      acc_d = ctl.acc_add ? (acc_q + mdr_q) : mdr_q;
    end

    out_d = ctl.out_ld ? acc_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
      cir_q <= cir_d;
      acc_q <= acc_d;
      out_q <= out_d;
      vld_q <= ctl.out_ld;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_we    = ctl.mem_wr;
  assign mem_wdata = acc_q;
  assign out_valid = vld_q;
  assign out_data  = out_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_inc |=> pc_q == $past(pc_q) + AW'(1)); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_ld |=> pc_q == $past(cir_q[AW-1:0])); // R8

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid); // R7

  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_wr |=> $stable(acc_q)); // R6

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          halted
);

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ctl_t            ctl;
  logic [OP_W-1:0] opcode;
  logic            mem_open;
  logic [AW-1:0]   cpu_addr;
  logic            cpu_we;
  logic [DW-1:0]   cpu_wdata;
  logic [DW-1:0]   mem_rdata;
  logic            host_we;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [DW-1:0]   mem_wdata;

  assign host_we   = load_we && mem_open;
  assign mem_we    = cpu_we || host_we;
  assign mem_waddr = cpu_we ? cpu_addr  : load_addr;
  assign mem_wdata = cpu_we ? cpu_wdata : load_data;

  acc_cpu_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .opcode   (opcode),
    .ctl      (ctl),
    .halted   (halted),
    .mem_open (mem_open)
  );

  acc_cpu_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (cpu_addr),
    .mem_we    (cpu_we),
    .mem_wdata (cpu_wdata),
    .opcode    (opcode),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  acc_cpu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (cpu_addr),
    .rdata (mem_rdata)
  );

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_we && !halted && (ctl != '0)) |-> !host_we); // R11

endmodule

// File: tb/tb_acc_cpu_top.sv
module tb_acc_cpu_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       load_we;
  logic [3:0] load_addr;
  logic [7:0] load_data;
  logic       out_valid;
  logic [7:0] out_data;
  logic       halted;

  always #5 clk = ~clk;

  acc_cpu_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_we   (load_we),
    .load_addr (load_addr),
    .load_data (load_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .halted    (halted)
  );

  typedef struct {
    logic [7:0] val;
    int         due;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] prog [16];
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;
  int         halt_due = 0;
  bit         running = 0;
  string      cur_req = "";

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference interpreter: fills the scoreboard with values and due cycles
  task automatic build_expect();
    logic [7:0] mm [16];
    logic [3:0] pc;
    logic [7:0] acc;
    logic [7:0] ins;
    logic [3:0] opc;
    logic [3:0] a;
    int         t;
    exp_t       e;
    for (int i = 0; i < 16; i++) mm[i] = prog[i];
    pc = 4'd0;
    acc = 8'd0;
    t = 1;
    halt_due = -1;
    expq.delete();
    for (int n = 0; n < 300; n++) begin
      ins = mm[pc];
      opc = ins[7:4];   // R3 upper nibble
      a   = ins[3:0];   // R3 lower nibble
      pc  = pc + 4'd1;
      case (opc)
        4'h1: begin acc = mm[a];         t += 8; end
        4'h2: begin acc = acc + mm[a];   t += 8; end
        4'h3: begin mm[a] = acc;         t += 7; end
        4'h5: begin e.val = acc; e.due = t + 6; expq.push_back(e); t += 6; end
        4'h6: begin pc = a;              t += 6; end
        4'h0: begin halt_due = t + 5; break; end
        default: t += 5;
      endcase
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      load_we   = 1'b1;
      load_addr = 4'(i);
      load_data = prog[i];
    end
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic run(input bit poke);
    int w;
    build_expect();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    cyc = 0;
    running = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      load_we   = 1'b1;
      load_addr = 4'hF;
      load_data = 8'hAA;
      @(negedge clk);
      load_we = 1'b0;
    end
    w = 0;
    while (running && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (running) begin
      check(1'b0, "R9", "run never halted", 0, 1);
      running = 1'b0;
    end
  endtask

  // Monitor: compares strobes and halt timing against the scoreboard
  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (out_valid === 1'b1) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7", "unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(out_data === e.val, cur_req, "output value", int'(out_data), int'(e.val));
          check(cyc == e.due, "R2/R7", "strobe cycle", cyc, e.due);
        end
      end
      if (halted === 1'b1) begin
        check(cyc == halt_due, "R9", "halt cycle", cyc, halt_due);
        check(expq.size() == 0, "R9", "outputs missing at halt", expq.size(), 0);
        running = 1'b0;
      end
    end else if (out_valid === 1'b1) begin
      check(1'b0, "R9", "strobe outside a run", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    load_we = 1'b0;
    load_addr = '0;
    load_data = '0;
    do_reset();

    // R1: reset state, and nothing moves without start
    check(halted === 1'b0, "R1", "halted after reset", int'(halted), 0);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_data === 8'h00, "R1", "out_data after reset", int'(out_data), 0);
    repeat (12) @(negedge clk);
    check(halted === 1'b0 && out_valid === 1'b0, "R1", "idle without start", int'(halted), 0);

    // Program A: R4 load, R5 add, R6 store then reload, R11 write during run ignored
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
    prog[0] = 8'h1C; prog[1] = 8'h2D; prog[2] = 8'h3E; prog[3] = 8'h50;
    prog[4] = 8'h1F; prog[5] = 8'h50; prog[6] = 8'h1E; prog[7] = 8'h50;
    prog[8] = 8'h00;
    prog[12] = 8'h03; prog[13] = 8'h01; prog[15] = 8'h09;
    load_prog();
    cur_req = "R4/R6/R11";
    run(1'b1);
    check(out_data === 8'h04, "R7", "out_data held after halt", int'(out_data), 4);

    // R9: halted is sticky and start is ignored
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(halted === 1'b1, "R9", "halted sticky after start", int'(halted), 1);
    check(out_data === 8'h04, "R9", "no new output after halt", int'(out_data), 4);

    // Program B loaded while halted (R11), modulo add (R5)
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
    prog[0] = 8'h1C; prog[1] = 8'h2D; prog[2] = 8'h50; prog[3] = 8'h2D;
    prog[4] = 8'h50; prog[5] = 8'h00;
    prog[12] = 8'hF0; prog[13] = 8'h25;
    load_prog();
    do_reset();
    check(halted === 1'b0, "R1", "halt cleared by reset", int'(halted), 0);
    cur_req = "R5/R11";
    run(1'b0);

    // Program C: jump skips code (R8)
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
    prog[0] = 8'h1C; prog[1] = 8'h64; prog[2] = 8'h50; prog[3] = 8'h00;
    prog[4] = 8'h2D; prog[5] = 8'h50; prog[6] = 8'h63;
    prog[12] = 8'h07; prog[13] = 8'h05;
    load_prog();
    do_reset();
    cur_req = "R8";
    run(1'b0);
    check(out_data === 8'h0C, "R8", "jump path result", int'(out_data), 12);

    // Program D: unused codes are no-ops (R10)
    for (int i = 0; i < 16; i++) prog[i] = 8'h00;
    prog[0] = 8'h1C; prog[1] = 8'h7D; prog[2] = 8'hFD; prog[3] = 8'h4D;
    prog[4] = 8'h8C; prog[5] = 8'h50; prog[6] = 8'h00;
    prog[12] = 8'h5A; prog[13] = 8'h11;
    load_prog();
    do_reset();
    cur_req = "R10";
    run(1'b0);
    check(out_data === 8'h5A, "R10", "accumulator untouched by no-ops", int'(out_data), 90);

    repeat (5) @(negedge clk);
    finish_up();
  end

endmodule